// File: doc/BRIEF.md
# Legacy Region Attribute Steering Unit

This block routes host memory accesses that land in the legacy window between 768 KB and 1 MB (addresses 0C0000h to 0FFFFFh). The window is cut into thirteen segments: twelve of 16 KB covering 0C0000h to 0EFFFFh, and one of 64 KB covering 0F0000h to 0FFFFFh. Each segment has a read-enable bit and a write-enable bit. For each access, the block decides whether main memory claims it or whether it goes out on the downstream I/O link. Because reads and writes have separate bits, a read and a write to the same address can be sent to different targets.

Software programs seven 8-bit attribute registers and one status register through a plain register port. Register reads are combinational. Register writes take effect on the next clock edge.

Requests arrive on a valid/ready stream. Each route decision leaves on a second valid/ready stream, one cycle after the request is accepted. The unit has one output slot. While a decision is held with `rsp_ready` low, `req_ready` stays low, and the decision and its flags do not change.

A request from an initiator other than the host processor is illegal if it targets a segment that is not both readable and writable. Such a request is tagged illegal, sent to the downstream link, and sets a sticky error flag.

Top module: `legacy_steer`

## Requirements
- R1: After reset, every register offset 90h–97h reads 00h, `err_flag` is 0, `rsp_valid` is 0 and `req_ready` is 1. As a result, every in-window access goes to the link.
- R2: Register map:
  - Offset 90h, bits 5:4, hold the attribute of segment 0F0000h–0FFFFFh.
  - Offsets 91h to 96h each hold two 16 KB segments in ascending address order starting at 0C0000h. Bits 1:0 hold the lower-addressed segment and bits 5:4 the upper one.
  - Offset 97h bit 0 reads the error flag.
  - Other offsets read 00h, and writes to them change nothing.
- R3: Reserved bits ignore writes and read back as zero. These are all bits except 5:4 at 90h, and bits 7:6 and 3:2 at 91h–96h.
- R4: In each 2-bit attribute field, the low bit is read-enable and the high bit is write-enable. A read goes to DRAM only if read-enable is 1, and a write goes to DRAM only if write-enable is 1; otherwise the access goes to the link (`rsp_to_dram`=0). Field values are 00 none, 01 reads only, 10 writes only, 11 both.
- R5: An address outside 0C0000h–0FFFFFh, including any address with a bit set above bit 19, is routed to DRAM and is never illegal.
- R6: A request is accepted when `req_valid` and `req_ready` are both 1, where `req_ready` = !`rsp_valid` || `rsp_ready`. The decision appears with `rsp_valid` on the next cycle. It stays unchanged while `rsp_valid` is 1 and `rsp_ready` is 0.
- R7: A register write in the same cycle as a request's acceptance does not affect that request. It does affect requests accepted later.
- R8: A request with `req_host`=0 to an in-window segment whose field is not 11 gives `rsp_illegal`=1 and `rsp_to_dram`=0. A host request is never illegal. A non-host request to a field-11 segment follows R4.
- R9: Accepting an illegal request sets `err_flag` on the next cycle. The flag stays set until offset 97h is written with bit 0 = 1. Writing 0 to that bit has no effect. If a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset for read and write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational from `cfg_addr`) |
| err_flag | output | 1 | Sticky illegal-access flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | 32 | Access byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_host | input | 1 | 1 = host processor, 0 = other initiator |
| rsp_valid | output | 1 | Route decision valid |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_to_dram | output | 1 | 1 = main memory claims the access, 0 = downstream link |
| rsp_illegal | output | 1 | Access was an illegal non-host access |

## Verification
The error flag can be set by an accepted illegal request in the same cycle that software writes 1 to the clear bit. The bench drives a non-host request into a disabled segment and the clearing write on the same falling edge. It then expects `err_flag` to read 1 after the rising edge, and expects a later lone clear to drop it to 0.

A second collision is a register write landing in the same cycle as a request's acceptance. The bench checks that the response reflects the old attribute and that the next request reflects the new one.

// File: rtl/legacy_steer_pkg.sv
package legacy_steer_pkg;
  localparam int SEG_COUNT = 13;
  localparam int ATTR_REGS = 7;
  localparam int SEG_W     = $clog2(SEG_COUNT);

  typedef struct packed {
    logic wr_en;
    logic rd_en;
  } seg_attr_t;

  typedef struct packed {
    logic to_dram;
    logic illegal;
  } route_t;
endpackage

// File: rtl/lsu_attr_regs.sv
module lsu_attr_regs
  import legacy_steer_pkg::*;
#(
  parameter int CFG_AW   = 8,
  parameter int REG_BASE = 'h90
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [7:0]                   cfg_wdata,
  input  logic                         set_err,
  output logic [7:0]                   cfg_rdata,
  output logic                         err_flag,
  output seg_attr_t [SEG_COUNT-1:0]    seg_attr
);
  localparam int STAT_OFF = REG_BASE + ATTR_REGS;

  logic [ATTR_REGS-1:0][7:0] regs_q;
  logic                      err_q;
  logic                      clr_err;

  function automatic logic [7:0] keep_mask(input int idx);
    return (idx == 0) ? 8'h30 : 8'h33;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (cfg_we) begin
      for (int r = 0; r < ATTR_REGS; r++) begin
        if (cfg_addr == CFG_AW'(REG_BASE + r)) regs_q[r] <= cfg_wdata & keep_mask(r);
      end
    end
  end

  assign clr_err = cfg_we && (cfg_addr == CFG_AW'(STAT_OFF)) && ((cfg_wdata & 8'h01) != 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (set_err) err_q <= 1'b1;
    else if (clr_err) err_q <= 1'b0;
  end

  assign err_flag = err_q;

  always_comb begin
    cfg_rdata = '0;
    for (int r = 0; r < ATTR_REGS; r++) begin
      if (cfg_addr == CFG_AW'(REG_BASE + r)) cfg_rdata = regs_q[r];
    end
    if (cfg_addr == CFG_AW'(STAT_OFF)) cfg_rdata = {7'b0, err_q};
  end

  generate
    for (genvar s = 0; s < SEG_COUNT - 1; s++) begin : g_seg
      if (s % 2 == 0) begin : g_lo
        assign seg_attr[s] = seg_attr_t'(regs_q[1 + s/2][1:0]);
      end else begin : g_hi
        assign seg_attr[s] = seg_attr_t'(regs_q[1 + s/2][5:4]);
      end
    end
  endgenerate
  assign seg_attr[SEG_COUNT-1] = seg_attr_t'(regs_q[0][5:4]);
endmodule

// File: rtl/lsu_seg_decode.sv
module lsu_seg_decode
  import legacy_steer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [SEG_W-1:0]  seg_idx
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(32'h000C_0000);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(32'h000F_FFFF);

  assign in_win  = (addr >= WIN_LO) && (addr <= WIN_HI);
  assign seg_idx = (addr[17:16] == 2'b11) ? SEG_W'(SEG_COUNT - 1) : SEG_W'(addr[17:14]);
endmodule

// File: rtl/lsu_route_stage.sv
module lsu_route_stage
  import legacy_steer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  output logic   in_ready,
  input  route_t in_route,
  output logic   out_valid,
  input  logic   out_ready,
  output route_t out_route
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     out_route <= '0;
    else if (in_valid && in_ready)  out_route <= in_route;
  end
endmodule

// File: rtl/legacy_steer.sv
module legacy_steer
  import legacy_steer_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CFG_AW   = 8,
  parameter int REG_BASE = 'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              err_flag,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_host,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_to_dram,
  output logic              rsp_illegal
);
  seg_attr_t [SEG_COUNT-1:0] seg_attr;
  seg_attr_t                 hit;
  logic                      in_win;
  logic [SEG_W-1:0]          seg_idx;
  logic                      dir_ok;
  logic                      set_err;
  route_t                    new_route;
  route_t                    held_route;

  lsu_attr_regs #(.CFG_AW(CFG_AW), .REG_BASE(REG_BASE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .set_err   (set_err),
    .cfg_rdata (cfg_rdata),
    .err_flag  (err_flag),
    .seg_attr  (seg_attr)
  );

  lsu_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (req_addr),
    .in_win  (in_win),
    .seg_idx (seg_idx)
  );

  always_comb begin
    hit = '0;
    for (int s = 0; s < SEG_COUNT; s++) begin
      if (seg_idx == SEG_W'(s)) hit = seg_attr[s];
    end
  end

  assign dir_ok              = req_write ? hit.wr_en : hit.rd_en;
  assign new_route.illegal   = in_win && !req_host && !(hit.rd_en && hit.wr_en);
  assign new_route.to_dram   = !in_win || (dir_ok && !new_route.illegal);
  assign set_err             = req_valid && req_ready && new_route.illegal;

  lsu_route_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_route  (new_route),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_route (held_route)
  );

  assign rsp_to_dram = held_route.to_dram;
  assign rsp_illegal = held_route.illegal;
endmodule

// File: rtl/legacy_steer_chk.sv
module legacy_steer_chk #(
  parameter int ADDR_W   = 32,
  parameter int CFG_AW   = 8,
  parameter int REG_BASE = 'h90
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic              err_flag,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_host,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_to_dram,
  input logic              rsp_illegal
);
  logic acc, clr_req, last_out, last_host;

  assign acc     = req_valid && req_ready;
  assign clr_req = cfg_we && (cfg_addr == CFG_AW'(REG_BASE + 7)) && ((cfg_wdata & 8'h01) != 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_out  <= 1'b0;
      last_host <= 1'b0;
    end else if (acc) begin
      last_out  <= !((req_addr >= ADDR_W'(32'h000C_0000)) && (req_addr <= ADDR_W'(32'h000F_FFFF)));
      last_host <= req_host;
    end
  end

  a_r6_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_to_dram) && $stable(rsp_illegal));
  a_r5_outside_to_dram: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && last_out |-> rsp_to_dram && !rsp_illegal);
  a_r8_host_never_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && last_host |-> !rsp_illegal);
  a_r8_illegal_to_link: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_illegal |-> !rsp_to_dram);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr_req |=> err_flag);
  a_r9_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(acc && !req_host));
  a_r3_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr == CFG_AW'(REG_BASE) |-> (cfg_rdata & 8'hCF) == 8'h00);
  a_r3_reserved_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr > CFG_AW'(REG_BASE)) && (cfg_addr < CFG_AW'(REG_BASE + 7)) |-> (cfg_rdata & 8'hCC) == 8'h00);
endmodule

bind legacy_steer legacy_steer_chk #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .REG_BASE(REG_BASE)) u_chk (.*);

// File: tb/sim_legacy_steer.sv
`timescale 1ns/1ps
module sim_legacy_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        err_flag;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = 32'h0;
  logic        req_write = 1'b0;
  logic        req_host = 1'b1;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_to_dram;
  logic        rsp_illegal;

  int   nvec  = 0;
  int   nfail = 0;
  bit   done  = 1'b0;
  logic [1:0] attr [13];
  logic       err_exp = 1'b0;

  always #2.5 clk = ~clk;

  legacy_steer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .err_flag(err_flag), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_host(req_host), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_to_dram(rsp_to_dram), .rsp_illegal(rsp_illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(tag, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  function automatic int seg_of(input logic [31:0] a);
    if (a >= 32'hF0000 && a <= 32'hFFFFF) return 12;
    if (a >= 32'hC0000 && a < 32'hF0000) return int'((a - 32'hC0000) / 32'h4000);
    return -1;
  endfunction

  function automatic logic [31:0] seg_addr(input int s, input bit last);
    if (s == 12) return last ? 32'hFFFFF : 32'hF0000;
    return 32'hC0000 + 32'(s) * 32'h4000 + (last ? 32'h3FFF : 32'h0);
  endfunction

  // expected route from the attribute model: {to_dram, illegal}
  function automatic logic [1:0] model(input logic [31:0] a, input bit wr, input bit host);
    int s;
    logic [1:0] f;
    logic ill, dir;
    s = seg_of(a);
    if (s < 0) return 2'b10;
    f   = attr[s];
    ill = !host && (f != 2'b11);
    dir = wr ? f[1] : f[0];
    return {dir && !ill, ill};
  endfunction

  task automatic program_all();
    for (int r = 0; r < 7; r++) begin
      logic [7:0] v;
      if (r == 0) v = {2'b00, attr[12], 4'h0};
      else        v = {2'b00, attr[2*r-1], 2'b00, attr[2*r-2]};
      cfg_write(8'h90 + 8'(r), v | ((r == 0) ? 8'hCF : 8'hCC));
      cfg_read("R3 reserved bits dropped", 8'h90 + 8'(r), v);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] a, input bit wr, input bit host);
    logic [1:0] e;
    e = model(a, wr, host);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_host = host; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R6 rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
    chk({tag, " R4 route"}, {31'h0, rsp_to_dram}, {31'h0, e[1]});
    chk({tag, " R8 illegal"}, {31'h0, rsp_illegal}, {31'h0, e[0]});
    if (e[0]) err_exp = 1'b1;
    chk({tag, " R9 err_flag"}, {31'h0, err_flag}, {31'h0, err_exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 13; s++) attr[s] = 2'b00;

    // R1 reset state
    for (int r = 0; r < 8; r++) cfg_read("R1 reset register", 8'h90 + 8'(r), 8'h00);
    chk("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk("R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
    chk("R1 err_flag after reset", {31'h0, err_flag}, 32'h0);
    send("R1 host read after reset", 32'hF8000, 1'b0, 1'b1);
    cfg_write(8'h97, 8'h01); err_exp = 1'b0;

    // R2 unmapped offsets
    cfg_write(8'h98, 8'hFF);
    cfg_read("R2 unmapped 98h", 8'h98, 8'h00);
    cfg_read("R2 unmapped 8Fh", 8'h8F, 8'h00);
    cfg_read("R2 no alias into 90h", 8'h90, 8'h00);

    // R2 R4 R8 sweep: every segment, every field value, both edges, both directions, both initiators
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 13; s++) attr[s] = 2'((s + p) % 4);
      program_all();
      for (int s = 0; s < 13; s++)
        for (int e = 0; e < 2; e++)
          for (int wr = 0; wr < 2; wr++)
            for (int h = 0; h < 2; h++)
              send("R2 sweep", seg_addr(s, e[0]), wr[0], h[0]);
    end
    cfg_read("R9 status readback", 8'h97, {7'h0, err_exp});

    // R9 clear rules
    cfg_write(8'h97, 8'h00);
    chk("R9 write zero keeps flag", {31'h0, err_flag}, {31'h0, err_exp});
    cfg_write(8'h97, 8'h01); err_exp = 1'b0;
    chk("R9 write one clears", {31'h0, err_flag}, 32'h0);

    // R5 outside the window, all attributes disabled
    for (int s = 0; s < 13; s++) attr[s] = 2'b00;
    program_all();
    send("R5 below window", 32'h000BFFFF, 1'b0, 1'b0);
    send("R5 above window", 32'h00100000, 1'b1, 1'b0);
    send("R5 zero", 32'h00000000, 1'b1, 1'b0);
    send("R5 high bits", 32'h100F0000, 1'b0, 1'b0);
    chk("R5 no error raised", {31'h0, err_flag}, 32'h0);

    // R9 set and clear in the same cycle: set wins
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'hF4000; req_write = 1'b0; req_host = 1'b0;
    cfg_we = 1'b1; cfg_addr = 8'h97; cfg_wdata = 8'h01;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    chk("R9 set beats clear", {31'h0, err_flag}, 32'h1);
    cfg_write(8'h97, 8'h01);
    chk("R9 lone clear", {31'h0, err_flag}, 32'h0);

    // R7 write in the acceptance cycle is not seen by that request
    attr[12] = 2'b11;
    program_all();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'hF0010; req_write = 1'b0; req_host = 1'b1;
    cfg_we = 1'b1; cfg_addr = 8'h90; cfg_wdata = 8'h00;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    chk("R7 old attribute used", {31'h0, rsp_to_dram}, 32'h1);
    attr[12] = 2'b00;
    send("R7 new attribute used", 32'hF0010, 1'b0, 1'b1);

    // R6 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'hF0000; req_write = 1'b1; req_host = 1'b1;
    @(negedge clk);
    req_addr = 32'h00200000;
    for (int k = 0; k < 3; k++) begin
      chk("R6 stalled valid", {31'h0, rsp_valid}, 32'h1);
      chk("R6 stalled ready low", {31'h0, req_ready}, 32'h0);
      chk("R6 stalled route held", {31'h0, rsp_to_dram}, 32'h0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 next request after release", {30'h0, rsp_valid, rsp_to_dram}, 32'h3);
    @(negedge clk);
    chk("R6 drained", {31'h0, rsp_valid}, 32'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule